// File: doc/BRIEF.md
# Indirect Test Register Access Bridge

This block reaches a bank of up to 32 internal test and configuration registers through a small window of four 16-bit management registers. The window holds a command/control word, a 16-bit staging word for outgoing write data, and two read-only result words. The result words together cover internal registers up to 32 bits wide. Management software sets the write data and then writes the control word. The control word carries the command bits, a test-mode enable and separate 5-bit read and write addresses.

A write command moves the staging word into the internal register named by the write address. A read command copies the internal register named by the read address into the two result words. Each command bit clears itself once its transfer has been carried out. The internal registers come in several widths. A narrow register appears right-aligned in the low result word, and a wide one spills its upper bits into the high result word. A one-cycle completion pulse tells the surrounding logic when the last requested transfer is finished. The serial management transport sits outside the block and drives the window port directly.

Top module: `indirect_test_bridge`

## Requirements
- R1: After synchronous reset all four window words read 0 and `xfer_done` is 0.
- R2: `mgmt_sel` picks the window word (0 = control, 1 = low result, 2 = high result, 3 = write staging). `mgmt_rdata` shows the selected word as it stood at the previous rising edge. A write with `mgmt_sel` = 3 stores `mgmt_wdata`.
- R3: Control word layout: bit 15 = read command, bit 14 = write command, bit 10 = test enable, bits 9:5 = read address, bits 4:0 = write address. Bits 13:11 always read 0.
- R4: A read command copies the internal register at the read address into the result words.
- R5: For an internal register narrower than 17 bits, the low result word holds its value from bit 0 upward and the high result word reads 0.
- R6: For an internal register wider than 16 bits, the low result word holds bits 15:0 and the high result word holds the bits from 16 upward, right-aligned.
- R7: A write command loads the staging word into bits 15:0 of the target register, trimmed to its width. Any bits above 15 keep their old value.
- R8: Internal register a is 8*(1 + a mod 4) bits wide. Its reset value is ((a+1) * 0x9E3779B9 mod 2^32), trimmed to that width.
- R9: Command bits read back as 0 once their transfer is done.
- R10: A control write with bit 10 clear performs no transfer, raises no `xfer_done`, and its command bits read back 0.
- R11: With both command bits set, the write is performed first. The read follows one cycle later and sees the newly written value.
- R12: `xfer_done` is a one-cycle pulse. For a single command it is high in the second cycle after the control-write edge; with both commands, in the third.
- R13: The result words ignore management writes. They change only on a read command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_we | input | 1 | Window write strobe |
| mgmt_sel | input | 2 | Window word select |
| mgmt_wdata | input | 16 | Window write data |
| mgmt_rdata | output | 16 | Registered window read data |
| xfer_done | output | 1 | Completion pulse for the last transfer |

## Verification
The hardest case is a combined command. The write must reach the bank before the read samples it, and the completion pulse must not appear between the two transfers. The stimulus writes a fresh staging value and then issues one control word carrying both commands at the same address. It checks that the pulse is absent in the second cycle and present in the third, and that the low result word returns the staging value while the high result word keeps the register's untouched upper bits. Gated commands are driven with the test enable clear, directly after a completed read, so that any stray transfer would show up as changed result words.

// File: rtl/itb_pkg.sv
package itb_pkg;
  localparam int WIN_W  = 16;
  localparam int ADDR_W = 5;

  localparam int CMD_RD_BIT  = 15;
  localparam int CMD_WR_BIT  = 14;
  localparam int TEST_EN_BIT = 10;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_RDLO = 2'd1,
    SEL_RDHI = 2'd2,
    SEL_WDAT = 2'd3
  } win_sel_e;

  function automatic int entry_width(input int idx);
    return 8 * (1 + (idx % 4));
  endfunction

  function automatic logic [31:0] entry_init(input int idx);
    logic [31:0] k;
    k = 32'(idx + 1);
    return k * 32'h9E37_79B9;
  endfunction

  function automatic logic [31:0] width_mask(input int w);
    if (w >= 32) return 32'hFFFF_FFFF;
    return (32'd1 << w) - 32'd1;
  endfunction
endpackage

// File: rtl/itb_bank.sv
module itb_bank
  import itb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int MAX_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIN_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [MAX_W-1:0]  rdata
);
  localparam logic [MAX_W-1:0] LOW_MASK = MAX_W'({WIN_W{1'b1}});

  logic [NUM_REGS-1:0][MAX_W-1:0] ent;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    localparam int               W    = (entry_width(g) > MAX_W) ? MAX_W : entry_width(g);
    localparam logic [MAX_W-1:0] MSK  = MAX_W'(width_mask(W));
    localparam logic [MAX_W-1:0] INIT = MAX_W'(entry_init(g)) & MSK;
    logic [MAX_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= INIT;
      end else if (we && (waddr == ADDR_W'(g))) begin
        q <= ((q & ~LOW_MASK) | MAX_W'(wdata)) & MSK;
      end
    end
    assign ent[g] = q;
  end

  always_comb begin
    if (int'(raddr) < NUM_REGS) rdata = ent[raddr];
    else                        rdata = '0;
  end
endmodule

// File: rtl/itb_engine.sv
module itb_engine
  import itb_pkg::*;
#(
  parameter int MAX_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pend_wr,
  input  logic              pend_rd,
  input  logic [MAX_W-1:0]  bank_rdata,
  output logic              bank_we,
  output logic              clr_wr,
  output logic              clr_rd,
  output logic [WIN_W-1:0]  rd_lo,
  output logic [WIN_W-1:0]  rd_hi,
  output logic              done
);
  logic do_wr, do_rd, last_xfer;

  // write always goes first; the read waits one cycle so it sees the new value
  assign do_wr   = pend_wr;
  assign do_rd   = pend_rd & ~pend_wr;
  assign bank_we = do_wr;
  assign clr_wr  = do_wr;
  assign clr_rd  = do_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_lo     <= '0;
      rd_hi     <= '0;
      last_xfer <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (do_rd) begin
        rd_lo <= bank_rdata[WIN_W-1:0];
        rd_hi <= WIN_W'(bank_rdata >> WIN_W);
      end
      last_xfer <= (do_wr & ~pend_rd) | do_rd;
      done      <= last_xfer;
    end
  end
endmodule

// File: rtl/itb_window.sv
module itb_window
  import itb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mgmt_we,
  input  logic [1:0]        mgmt_sel,
  input  logic [WIN_W-1:0]  mgmt_wdata,
  input  logic [WIN_W-1:0]  rd_lo,
  input  logic [WIN_W-1:0]  rd_hi,
  input  logic              clr_wr,
  input  logic              clr_rd,
  output logic              pend_wr,
  output logic              pend_rd,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W-1:0] waddr,
  output logic [WIN_W-1:0]  wdat_q,
  output logic [WIN_W-1:0]  mgmt_rdata
);
  logic              test_en;
  logic              ctrl_wr;
  logic [WIN_W-1:0]  ctrl_view;
  logic              unused_rsv;

  assign ctrl_wr    = mgmt_we && (win_sel_e'(mgmt_sel) == SEL_CTRL);
  assign unused_rsv = ^{mgmt_wdata[13:11]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_wr <= 1'b0;
      pend_rd <= 1'b0;
      test_en <= 1'b0;
      raddr   <= '0;
      waddr   <= '0;
      wdat_q  <= '0;
    end else begin
      if (clr_wr) pend_wr <= 1'b0;
      if (clr_rd) pend_rd <= 1'b0;
      if (ctrl_wr) begin
        test_en <= mgmt_wdata[TEST_EN_BIT];
        raddr   <= mgmt_wdata[9:5];
        waddr   <= mgmt_wdata[4:0];
        if (mgmt_wdata[TEST_EN_BIT] && mgmt_wdata[CMD_WR_BIT]) pend_wr <= 1'b1;
        if (mgmt_wdata[TEST_EN_BIT] && mgmt_wdata[CMD_RD_BIT]) pend_rd <= 1'b1;
      end
      if (mgmt_we && (win_sel_e'(mgmt_sel) == SEL_WDAT)) wdat_q <= mgmt_wdata;
    end
  end

  assign ctrl_view = {pend_rd, pend_wr, 3'b000, test_en, raddr, waddr};

  always_ff @(posedge clk) begin
    if (rst) begin
      mgmt_rdata <= '0;
    end else begin
      case (win_sel_e'(mgmt_sel))
        SEL_CTRL: mgmt_rdata <= ctrl_view;
        SEL_RDLO: mgmt_rdata <= rd_lo;
        SEL_RDHI: mgmt_rdata <= rd_hi;
        default:  mgmt_rdata <= wdat_q;
      endcase
    end
  end
endmodule

// File: rtl/indirect_test_bridge.sv
module indirect_test_bridge
  import itb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int MAX_W    = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mgmt_we,
  input  logic [1:0]  mgmt_sel,
  input  logic [15:0] mgmt_wdata,
  output logic [15:0] mgmt_rdata,
  output logic        xfer_done
);
  logic              pend_wr, pend_rd, clr_wr, clr_rd, bank_we;
  logic [ADDR_W-1:0] raddr, waddr;
  logic [WIN_W-1:0]  wdat_q, rd_lo, rd_hi;
  logic [MAX_W-1:0]  bank_rdata;

  itb_window u_win (
    .clk(clk), .rst(rst), .mgmt_we(mgmt_we), .mgmt_sel(mgmt_sel),
    .mgmt_wdata(mgmt_wdata), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .clr_wr(clr_wr), .clr_rd(clr_rd), .pend_wr(pend_wr), .pend_rd(pend_rd),
    .raddr(raddr), .waddr(waddr), .wdat_q(wdat_q), .mgmt_rdata(mgmt_rdata)
  );

  itb_engine #(.MAX_W(MAX_W)) u_eng (
    .clk(clk), .rst(rst), .pend_wr(pend_wr), .pend_rd(pend_rd),
    .bank_rdata(bank_rdata), .bank_we(bank_we), .clr_wr(clr_wr),
    .clr_rd(clr_rd), .rd_lo(rd_lo), .rd_hi(rd_hi), .done(xfer_done)
  );

  itb_bank #(.NUM_REGS(NUM_REGS), .MAX_W(MAX_W)) u_bank (
    .clk(clk), .rst(rst), .we(bank_we), .waddr(waddr), .wdata(wdat_q),
    .raddr(raddr), .rdata(bank_rdata)
  );
endmodule

// File: rtl/itb_checker.sv
module itb_checker (
  input logic        clk,
  input logic        rst,
  input logic        mgmt_we,
  input logic [1:0]  mgmt_sel,
  input logic        ctrl_test_bit,
  input logic        pend_wr,
  input logic        pend_rd,
  input logic [15:0] rd_lo,
  input logic [15:0] rd_hi,
  input logic        xfer_done
);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  // R12
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> ($past(pend_rd && !pend_wr, 2) || $past(pend_wr && !pend_rd, 2)));

  // R9
  wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_wr && !(mgmt_we && mgmt_sel == 2'd0)) |=> !pend_wr);

  // R11
  order_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_wr && pend_rd) |=> pend_rd);

  // R10
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    (mgmt_we && mgmt_sel == 2'd0 && !ctrl_test_bit && !pend_wr && !pend_rd)
      |=> (!pend_wr && !pend_rd));

  // R13
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(pend_rd && !pend_wr) |=> ($stable(rd_lo) && $stable(rd_hi)));
endmodule

bind indirect_test_bridge itb_checker u_chk (
  .clk(clk), .rst(rst), .mgmt_we(mgmt_we), .mgmt_sel(mgmt_sel),
  .ctrl_test_bit(mgmt_wdata[10]), .pend_wr(pend_wr), .pend_rd(pend_rd),
  .rd_lo(rd_lo), .rd_hi(rd_hi), .xfer_done(xfer_done)
);

// File: tb/tb_indirect_test_bridge.sv
module tb_indirect_test_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mgmt_we = 1'b0;
  logic [1:0]  mgmt_sel = 2'd0;
  logic [15:0] mgmt_wdata = 16'd0;
  logic [15:0] mgmt_rdata;
  logic        xfer_done;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct { logic [15:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  logic arm = 1'b0;
  logic cmp_now = 1'b0;

  logic [31:0] bank_m [32];

  always #2 clk = ~clk;

  indirect_test_bridge dut (
    .clk(clk), .rst(rst), .mgmt_we(mgmt_we), .mgmt_sel(mgmt_sel),
    .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata), .xfer_done(xfer_done)
  );

  function automatic int m_width(input int a);
    return 8 * (1 + (a % 4));
  endfunction

  function automatic logic [31:0] m_mask(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare the registered read data against the queued expectation
  always @(posedge clk) cmp_now <= arm;
  always @(negedge clk) begin
    if (cmp_now) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL scoreboard: actual %h expected none", mgmt_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(mgmt_rdata, e.val, e.tag);
      end
    end
  end

  task automatic win_wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    mgmt_we = 1'b1; mgmt_sel = sel; mgmt_wdata = d;
    @(negedge clk);
    mgmt_we = 1'b0;
  endtask

  task automatic win_rd(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    mgmt_sel = sel;
    e.val = exp; e.tag = tag;
    exp_q.push_back(e);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic model_write(input int a, input logic [15:0] d);
    bank_m[a] = ((bank_m[a] & 32'hFFFF_0000) | {16'd0, d}) & m_mask(m_width(a));
  endtask

  // issue a control word and check the completion pulse; dc = 0 means never
  task automatic cmd(input logic [15:0] ctrl, input int dc, input string tag);
    win_wr(2'd0, ctrl);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check({15'd0, xfer_done}, {15'd0, (k == dc)}, tag);
    end
  endtask

  function automatic logic [15:0] ctl(input bit rd, input bit wr, input bit te,
                                      input int ra, input int wa);
    return {rd, wr, 3'b000, te, 5'(ra), 5'(wa)};
  endfunction

  initial begin
    for (int a = 0; a < 32; a++)
      bank_m[a] = (32'(a + 1) * 32'h9E37_79B9) & m_mask(m_width(a));

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check({15'd0, xfer_done}, 16'd0, "R1 done");
    win_rd(2'd0, 16'h0000, "R1 ctrl");
    win_rd(2'd1, 16'h0000, "R1 rdlo");
    win_rd(2'd2, 16'h0000, "R1 rdhi");
    win_rd(2'd3, 16'h0000, "R1 wdat");

    // R2 staging word, R13 result words ignore writes
    win_wr(2'd3, 16'h1234);
    win_rd(2'd3, 16'h1234, "R2 wdat");
    win_wr(2'd1, 16'hFFFF);
    win_wr(2'd2, 16'hABCD);
    win_rd(2'd1, 16'h0000, "R13 rdlo ignores write");
    win_rd(2'd2, 16'h0000, "R13 rdhi ignores write");

    // R3 layout, reserved bits read 0
    win_wr(2'd0, 16'h3800 | ctl(0, 0, 1, 5, 7));
    win_rd(2'd0, ctl(0, 0, 1, 5, 7), "R3 ctrl layout");

    // R4 R5 R8 narrow read (addr 0, 8 bits)
    cmd(ctl(1, 0, 1, 0, 0), 2, "R12 read done");
    win_rd(2'd1, bank_m[0][15:0], "R5 narrow lo");
    win_rd(2'd2, 16'h0000, "R5 narrow hi");
    win_rd(2'd0, ctl(0, 0, 1, 0, 0), "R9 cmd cleared");

    // R6 R8 wide reads
    cmd(ctl(1, 0, 1, 3, 0), 2, "R12 read done");
    win_rd(2'd1, bank_m[3][15:0], "R6 wide32 lo");
    win_rd(2'd2, bank_m[3][31:16], "R6 wide32 hi");
    cmd(ctl(1, 0, 1, 2, 0), 2, "R12 read done");
    win_rd(2'd1, bank_m[2][15:0], "R4 wide24 lo");
    win_rd(2'd2, bank_m[2][31:16], "R6 wide24 hi");
    cmd(ctl(1, 0, 1, 1, 0), 2, "R12 read done");
    win_rd(2'd2, 16'h0000, "R5 16-bit hi");

    // R7 writes to 24-bit and 8-bit entries
    win_wr(2'd3, 16'hBEEF);
    cmd(ctl(0, 1, 1, 0, 2), 2, "R12 write done");
    model_write(2, 16'hBEEF);
    win_rd(2'd0, ctl(0, 0, 1, 0, 2), "R9 write cmd cleared");
    cmd(ctl(0, 1, 1, 0, 4), 2, "R12 write done");
    model_write(4, 16'hBEEF);
    cmd(ctl(1, 0, 1, 2, 0), 2, "R12 read done");
    win_rd(2'd1, bank_m[2][15:0], "R7 wide lo written");
    win_rd(2'd2, bank_m[2][31:16], "R7 wide hi kept");
    cmd(ctl(1, 0, 1, 4, 0), 2, "R12 read done");
    win_rd(2'd1, bank_m[4][15:0], "R7 narrow trimmed");

    // R11 combined: write then read, same address (24-bit entry 6)
    win_wr(2'd3, 16'h5A5A);
    cmd(ctl(1, 1, 1, 6, 6), 3, "R11 combined done");
    model_write(6, 16'h5A5A);
    win_rd(2'd1, bank_m[6][15:0], "R11 read sees write lo");
    win_rd(2'd2, bank_m[6][31:16], "R11 read sees write hi");
    win_rd(2'd0, ctl(0, 0, 1, 6, 6), "R9 both cleared");

    // R10 gated commands with test enable clear
    win_wr(2'd3, 16'h1111);
    cmd(ctl(1, 1, 0, 1, 1), 0, "R10 no done");
    win_rd(2'd0, ctl(0, 0, 0, 1, 1), "R10 cmd bits clear");
    win_rd(2'd1, bank_m[6][15:0], "R10 rdlo untouched");
    cmd(ctl(1, 0, 1, 1, 0), 2, "R12 read done");
    win_rd(2'd1, bank_m[1][15:0], "R10 bank untouched");

    // R13 non-command control write leaves results alone
    win_wr(2'd0, ctl(0, 0, 1, 9, 9));
    win_rd(2'd1, bank_m[1][15:0], "R13 results held");

    // R7 R6 write to 32-bit entry 31 keeps upper half
    win_wr(2'd3, 16'h0F0F);
    cmd(ctl(0, 1, 1, 0, 31), 2, "R12 write done");
    model_write(31, 16'h0F0F);
    cmd(ctl(1, 0, 1, 31, 0), 2, "R12 read done");
    win_rd(2'd1, bank_m[31][15:0], "R7 entry31 lo");
    win_rd(2'd2, bank_m[31][31:16], "R6 entry31 hi");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: actual %0d expected 0 pending", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule